// File: doc/BRIEF.md
# Lane-Marking Horizontal Filter

This block scans a raster stream of 8-bit grey pixels, taken from a road image whose perspective has already been removed, and marks pixels that look like part of a painted lane line. On a corrected image a marking is a narrow bright stripe with darker road on both sides. For each pixel the block compares the centre value with the pixels exactly two places to its left and to its right on the same line. It returns a grey strength value that is non-zero only for a dark-bright-dark pattern. It also returns a one-bit marker, set when the strength exceeds a threshold.

Pixels enter through a valid/ready port that carries start-of-line and end-of-line flags. Results leave through a registered valid/ready port, one result per pixel of the line, with the line flags moved to the delayed results. The threshold is a run-time input. An optional adaptive mode raises the threshold inside a line to a power-of-two fraction of the strongest response seen so far on that line.

The control is a three-state machine. `ST_IDLE` waits for a pixel flagged as start-of-line. Transition *line-open* goes to `ST_LINE`, and transition *single-pixel line* goes straight to `ST_FLUSH` when that pixel also carries end-of-line. `ST_LINE` accepts pixels and emits the result for the pixel two places back. Transition *line-close* goes to `ST_FLUSH` on the end-of-line pixel. `ST_FLUSH` refuses input and emits the pending pixels of the line. Transition *drained* returns to `ST_IDLE` after the last of them.

Top module: `lane_mark_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For a pixel of value c with left neighbour l and right neighbour r, both 2 positions away on the same line, the response is min(c−l, c−r) when c > l and c > r. Otherwise it is 0, so ties count as no marking.
- R3: Pixels at positions 0, 1, n−2 and n−1 of a line of n pixels have response 0.
- R4: With `adapt_en` = 0, `out_mark` is 1 exactly when the response is strictly greater than `thr`.
- R5: With `adapt_en` = 1, the effective threshold is max(`thr`, M >> `adapt_sh`). M is the largest response among earlier pixels of the same line and is 0 for the first pixel of a line. `out_mark` is 1 exactly when the response is strictly greater than that value.
- R6: The result for pixel j is loaded into the output register at the clock edge that accepts pixel j+2. After the end-of-line pixel is accepted, the last two results are emitted without further input, and `in_ready` stays 0 while they drain.
- R7: Every pixel of a line yields exactly one result, in order. `out_sol` is set on the result for position 0 and `out_eol` on the result for the last position.
- R8: While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values and no result is lost.
- R9: Pixels accepted while no line is open (`in_sol` = 0 in the idle state) are discarded and produce no result.
- R10: Lines of one or two pixels produce one or two results, all with response 0, carrying the correct flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pix | input | 8 | Grey value of the input pixel |
| in_sol | input | 1 | Input pixel is first of its line |
| in_eol | input | 1 | Input pixel is last of its line |
| thr | input | 8 | Threshold for the marker bit |
| adapt_en | input | 1 | 1 selects the per-line adaptive threshold |
| adapt_sh | input | 3 | Right shift applied to the line's running maximum |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_resp | output | 8 | Grey strength of the dark-bright-dark pattern |
| out_mark | output | 1 | Strength exceeds the effective threshold |
| out_sol | output | 1 | Result belongs to position 0 of the line |
| out_eol | output | 1 | Result belongs to the last position of the line |

## Verification
The assertions assume well-formed lines: each line opens with one `in_sol` pixel, closes with one `in_eol` pixel, and has no second start flag inside it. `thr`, `adapt_en` and `adapt_sh` are assumed steady across a line. The stimulus sends whole lines with exactly one flag of each kind. It changes the threshold settings only between lines, once all results of the previous line are out. Stray unflagged pixels are sent only while the block is idle, and the back-pressure pattern on `out_ready` is changed half a cycle away from the pixel drive.

// File: rtl/lmf_pkg.sv
package lmf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINE  = 2'd1,
        ST_FLUSH = 2'd2
    } lmf_state_e;
endpackage

// File: rtl/lmf_window.sv
module lmf_window #(
    parameter int PIX_W = 8,
    parameter int DIST  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] centre,
    output logic [PIX_W-1:0] left_px
);
    localparam int DEPTH = 2 * DIST;

    logic [PIX_W-1:0] tap [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_tap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tap[g] <= '0;
                end else if (push) begin
                    if (g == 0) tap[g] <= din;
                    else        tap[g] <= tap[g-1];
                end
            end
        end
    endgenerate

    assign centre  = tap[DIST-1];
    assign left_px = tap[DEPTH-1];
endmodule

// File: rtl/lmf_resp.sv
module lmf_resp #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] left_px,
    input  logic [PIX_W-1:0] centre,
    input  logic [PIX_W-1:0] right_px,
    input  logic             zero_edge,
    output logic [PIX_W-1:0] resp
);
    logic [PIX_W-1:0] dl;
    logic [PIX_W-1:0] dr;

    always_comb begin
        dl   = centre - left_px;
        dr   = centre - right_px;
        resp = '0;
        if (!zero_edge && (centre > left_px) && (centre > right_px))
            resp = (dl < dr) ? dl : dr;
    end
endmodule

// File: rtl/lmf_thresh.sv
module lmf_thresh #(
    parameter int PIX_W = 8,
    parameter int SH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit,
    input  logic             first,
    input  logic [PIX_W-1:0] resp,
    input  logic [PIX_W-1:0] thr,
    input  logic             adapt_en,
    input  logic [SH_W-1:0]  adapt_sh,
    output logic             mark
);
    logic [PIX_W-1:0] run_max;
    logic [PIX_W-1:0] prev_max;
    logic [PIX_W-1:0] frac;
    logic [PIX_W-1:0] eff;

    always_comb begin
        prev_max = first ? '0 : run_max;
        frac     = prev_max >> adapt_sh;
        eff      = thr;
        if (adapt_en && (frac > thr))
            eff = frac;
        mark = resp > eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_max <= '0;
        else if (emit)
            run_max <= (resp > prev_max) ? resp : prev_max;
    end

    // the marker never fires at or below the programmed floor
    p_mark_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && mark) |-> (resp > thr));
endmodule

// File: rtl/lane_mark_filter.sv
module lane_mark_filter #(
    parameter int PIX_W = 8,
    parameter int DIST  = 2,
    parameter int SH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sol,
    input  logic             in_eol,
    input  logic [PIX_W-1:0] thr,
    input  logic             adapt_en,
    input  logic [SH_W-1:0]  adapt_sh,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_resp,
    output logic             out_mark,
    output logic             out_sol,
    output logic             out_eol
);
    import lmf_pkg::*;

    localparam int              CW   = $clog2(DIST + 1);
    localparam logic [CW-1:0]   FULL = CW'(DIST);
    localparam logic [CW-1:0]   ONE  = CW'(1);

    lmf_state_e       state, state_n;
    logic [CW-1:0]    pend, pend_n;
    logic [CW-1:0]    ecnt, ecnt_n;
    logic             adv, acc, push, emit_run, emit_fl, emit;
    logic             zero_edge, first;
    logic [PIX_W-1:0] centre, left_px, resp_w;
    logic             mark_w;

    assign adv       = !out_valid || out_ready;
    assign in_ready  = adv && (state != ST_FLUSH);
    assign acc       = in_valid && in_ready;
    assign push      = acc && ((state == ST_LINE) || ((state == ST_IDLE) && in_sol));
    assign emit_run  = acc && (state == ST_LINE) && (pend == FULL);
    assign emit_fl   = (state == ST_FLUSH) && adv;
    assign emit      = emit_run || emit_fl;
    assign zero_edge = emit_fl || (ecnt < FULL);
    assign first     = (ecnt == '0);

    lmf_window #(.PIX_W(PIX_W), .DIST(DIST)) i_window (
        .clk(clk), .rst_n(rst_n), .push(push), .din(in_pix),
        .centre(centre), .left_px(left_px)
    );

    lmf_resp #(.PIX_W(PIX_W)) i_resp (
        .left_px(left_px), .centre(centre), .right_px(in_pix),
        .zero_edge(zero_edge), .resp(resp_w)
    );

    lmf_thresh #(.PIX_W(PIX_W), .SH_W(SH_W)) i_thresh (
        .clk(clk), .rst_n(rst_n), .emit(emit), .first(first),
        .resp(resp_w), .thr(thr), .adapt_en(adapt_en),
        .adapt_sh(adapt_sh), .mark(mark_w)
    );

    always_comb begin
        state_n = state;
        pend_n  = pend;
        ecnt_n  = ecnt;
        unique case (state)
            ST_IDLE: begin
                if (acc && in_sol) begin
                    pend_n  = ONE;
                    ecnt_n  = '0;
                    state_n = in_eol ? ST_FLUSH : ST_LINE;
                end
            end
            ST_LINE: begin
                if (acc) begin
                    if (pend != FULL) pend_n = pend + ONE;
                    if (in_eol)       state_n = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (adv) begin
                    pend_n = pend - ONE;
                    if (pend == ONE) state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (emit && (ecnt != FULL))
            ecnt_n = ecnt + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= '0;
            ecnt  <= '0;
        end else begin
            state <= state_n;
            pend  <= pend_n;
            ecnt  <= ecnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_resp  <= '0;
            out_mark  <= 1'b0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
        end else if (adv) begin
            out_valid <= emit;
            if (emit) begin
                out_resp <= resp_w;
                out_mark <= mark_w;
                out_sol  <= first;
                out_eol  <= emit_fl && (pend == ONE);
            end
        end
    end

    p_sol_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sol) |-> (out_resp == '0));

    p_eol_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eol) |-> (out_resp == '0));

    p_mark_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mark) |-> (out_resp != '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_resp) &&
            $stable(out_mark) && $stable(out_sol) && $stable(out_eol)));
endmodule

// File: tb/test_lane_mark_filter.sv
module test_lane_mark_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_pix = '0;
    logic       in_sol = 1'b0;
    logic       in_eol = 1'b0;
    logic [7:0] thr = 8'd30;
    logic       adapt_en = 1'b0;
    logic [2:0] adapt_sh = 3'd1;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_resp;
    logic       out_mark, out_sol, out_eol;

    int errors = 0;
    int checks = 0;
    int idx = 0;
    int cyc = 0;
    bit bp_on = 1'b0;
    bit done = 1'b0;

    logic [7:0] lp    [0:63];
    logic [7:0] g_resp[0:255];
    logic       g_mark[0:255];
    logic       g_sol [0:255];
    logic       g_eol [0:255];

    lane_mark_filter i_lane_mark_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_sol(in_sol), .in_eol(in_eol), .thr(thr),
        .adapt_en(adapt_en), .adapt_sh(adapt_sh), .out_valid(out_valid),
        .out_ready(out_ready), .out_resp(out_resp), .out_mark(out_mark),
        .out_sol(out_sol), .out_eol(out_eol)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #2;
        cyc++;
        out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && idx < 256) begin
            g_resp[idx] = out_resp;
            g_mark[idx] = out_mark;
            g_sol[idx]  = out_sol;
            g_eol[idx]  = out_eol;
            idx++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_pix(input logic [7:0] p, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_pix = p; in_sol = s; in_eol = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    endtask

    task automatic wait_count(input int target);
        for (int k = 0; k < 400 && idx < target; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic verify_line(input int n, input int base, input string tag);
        int runmax = 0;
        chk(idx == base + n, {tag, " R7 result count"}, idx - base, n);
        for (int j = 0; j < n; j++) begin
            int c, l, r, er, eff, a;
            bit em, es, ee;
            er = 0;
            if (j >= 2 && j <= n - 3) begin
                c = lp[j]; l = lp[j-2]; r = lp[j+2];
                if (c > l && c > r) er = ((c - l) < (c - r)) ? (c - l) : (c - r);
            end
            eff = thr;
            if (adapt_en && ((runmax >> adapt_sh) > eff)) eff = runmax >> adapt_sh;
            em = er > eff;
            if (er > runmax) runmax = er;
            es = (j == 0);
            ee = (j == n - 1);
            a = {g_resp[base+j], g_mark[base+j], g_sol[base+j], g_eol[base+j]};
            chk(a == {er[7:0], em, es, ee},
                $sformatf("%s R2/R3/R4/R5/R7 pos %0d {resp,mark,sol,eol}", tag, j),
                a, {er[7:0], em, es, ee});
        end
    endtask

    task automatic send_line(input int n, input string tag);
        int base = idx;
        for (int j = 0; j < n; j++) push_pix(lp[j], j == 0, j == n - 1);
        wait_count(base + n);
        verify_line(n, base, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_latency();
        int base = idx;
        for (int j = 0; j < 4; j++) lp[j] = 8'(10 * (j + 1));
        push_pix(lp[0], 1, 0);
        push_pix(lp[1], 0, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 no result before pixel 2", out_valid, 0);
        push_pix(lp[2], 0, 0);
        @(negedge clk);
        chk(out_valid && out_sol, "R6 result 0 after pixel 2 accepted",
            {out_valid, out_sol}, 3);
        push_pix(lp[3], 0, 1);
        @(negedge clk);
        chk(in_ready == 1'b0, "R6 in_ready low while draining", in_ready, 0);
        wait_count(base + 4);
        verify_line(4, base, "latency");
    endtask

    task automatic t_static();
        thr = 8'd30; adapt_en = 1'b0;
        for (int j = 0; j < 20; j++) lp[j] = 8'd40;
        lp[1] = 8'd255; lp[5] = 8'd120; lp[9] = 8'd60;
        lp[12] = 8'd200; lp[14] = 8'd210; lp[16] = 8'd71; lp[18] = 8'd250;
        send_line(20, "static");
        thr = 8'd79;
        send_line(20, "static thr79");
    endtask

    task automatic t_adaptive();
        thr = 8'd5; adapt_en = 1'b1; adapt_sh = 3'd1;
        for (int j = 0; j < 24; j++) lp[j] = 8'd10;
        lp[3] = 8'd110; lp[7] = 8'd70; lp[11] = 8'd50; lp[15] = 8'd61; lp[19] = 8'd12;
        send_line(24, "adaptive R5");
        adapt_sh = 3'd2;
        send_line(24, "adaptive sh2 R5");
        adapt_en = 1'b0; thr = 8'd30;
    endtask

    task automatic t_short();
        lp[0] = 8'd200; lp[1] = 8'd10; lp[2] = 8'd250;
        send_line(1, "short1 R10");
        send_line(2, "short2 R10");
        send_line(3, "short3 R10");
    endtask

    task automatic t_discard();
        int base = idx;
        push_pix(8'd255, 0, 0);
        push_pix(8'd0, 0, 0);
        push_pix(8'd255, 0, 1);
        repeat (6) @(negedge clk);
        chk(idx == base, "R9 stray pixels give no result", idx - base, 0);
        for (int j = 0; j < 8; j++) lp[j] = (j == 4) ? 8'd90 : 8'd20;
        send_line(8, "after discard R9");
    endtask

    task automatic t_backpressure();
        bp_on = 1'b1;
        for (int j = 0; j < 30; j++) lp[j] = 8'((j * 37 + 11) % 256);
        send_line(30, "backpressure R8");
        bp_on = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_latency();
        t_static();
        t_adaptive();
        t_short();
        t_discard();
        t_backpressure();
        finish_run();
    end
endmodule